// File: doc/BRIEF.md
# Tagged Operand Reorder Queue

This block sits in front of a DSP register file and lets a host processor prefill operands before the DSP code needs them. The host pushes 16-bit items over a 32-bit write port, two items per data write, after a header write that assigns a 4-bit destination tag to each of the next eight data writes. Each tag names one of sixteen logical DSP registers. Items wait in a 16-entry queue, kept in arrival order. Each entry holds a tag and a valid flag.

On the DSP side, a logical register that holds no value fills itself from the oldest queued item that carries its tag. The DSP program reads registers in any order it likes. Reading a register consumes its value, and the register then refills on its own, with no explicit load. If nothing in the queue matches, the read stalls and no stale value is delivered. Results go back to the host through an 8-deep, 32-bit output FIFO. The host learns about queue level, overflow and FIFO state only by polling status outputs. The block raises no interrupt.

Top module: `reorder_iq`

## Requirements
- R1: After reset the input queue is empty (`in_level_o` = 0), `in_ovf_o` is 0, every logical register is empty (`rd_ok_o` = 0), `res_empty_o` is 1 and `res_full_o` is 0.
- R2: A write with `wr_hdr_i` = 1 is a header. It loads eight tags and restarts the beat count at 0. Data beat k (k = 0..7, counted from the header) gives both of its items the tag in header bits [4k+3:4k]. After eight data beats the count wraps to 0 and the same header is used again.
- R3: A data write (`wr_hdr_i` = 0) carries two items, with bits [15:0] queued ahead of bits [31:16]. `in_level_o` rises by 2 at the edge that accepts the write, so one header beat and eight data beats move sixteen items.
- R4: An empty register whose index equals the tag of a queued item loads the oldest such item and removes it from the queue. At most one register loads per cycle, and the lowest register index goes first.
- R5: An item written at clock edge t can reach its register at edge t+1 at the earliest. `rd_data_o` and `rd_ok_o` show the register selected by `rd_reg_i` combinationally.
- R6: A read (`rd_req_i` high while `rd_ok_o` is high) consumes the register at that edge. The register may refill at the same edge, so one register can deliver one item per cycle. Items with the same tag come out in arrival order.
- R7: A read of an empty register drives `stall_o` high, consumes nothing and returns no value (`rd_ok_o` = 0).
- R8: A data write that arrives while `in_level_o` > 14 (queue depth minus two) is dropped whole and leaves the level unchanged. It sets `in_ovf_o`, which stays set until reset.
- R9: The output FIFO holds 8 words in first-in, first-out order, and `res_data_o` shows the oldest word. A push while full is dropped and a pop while empty is ignored. `res_full_o` and `res_empty_o` report the two limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host write strobe |
| wr_hdr_i | input | 1 | 1: header beat with eight tags, 0: data beat |
| wr_data_i | input | 32 | Host write word |
| in_level_o | output | 5 | Items waiting in the input queue |
| in_ovf_o | output | 1 | Sticky flag for a dropped data write |
| rd_req_i | input | 1 | DSP read request |
| rd_reg_i | input | 4 | Logical register to read |
| rd_data_o | output | 16 | Value held in the selected register |
| rd_ok_o | output | 1 | Selected register holds a value |
| stall_o | output | 1 | Read requested from an empty register |
| res_push_i | input | 1 | DSP result push |
| res_data_i | input | 32 | DSP result word |
| res_pop_i | input | 1 | Host result pop |
| res_data_o | output | 32 | Oldest result word |
| res_full_o | output | 1 | Output FIFO full |
| res_empty_o | output | 1 | Output FIFO empty |

## Verification
An accepted write changes `in_level_o` at the same clock edge. A matching empty register fills one edge later. A consumed register can refill at the very edge that consumes it. The output FIFO's flags and head word change at the edge of the push or pop. The bench drives inputs on falling edges and reads the combinational read port and status just before the next rising edge. The exact-timing cases, such as the one-cycle refill delay and the back-to-back stream from one register, are checked in the cycle where each result is due. Cases that do not depend on timing are checked after a few idle cycles.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_W  = 4;
  localparam int ITEM_W = 16;
  localparam int BUS_W  = 32;
  localparam int NREG   = 1 << TAG_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ITEM_W-1:0] data;
  } iq_item_t;
endpackage

// File: rtl/iq_hdr.sv
module iq_hdr
  import iq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             wr_hdr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic             push_o,
  output iq_item_t         item0_o,
  output iq_item_t         item1_o
);
  localparam int BEATS  = BUS_W / TAG_W;
  localparam int BEAT_W = $clog2(BEATS);

  logic [BUS_W-1:0]  tags_q;
  logic [BEAT_W-1:0] beat_q;
  logic [TAG_W-1:0]  tag;

  assign push_o = wr_valid_i & ~wr_hdr_i;
  assign tag    = tags_q[beat_q*TAG_W +: TAG_W];

  assign item0_o = '{tag: tag, data: wr_data_i[ITEM_W-1:0]};
  assign item1_o = '{tag: tag, data: wr_data_i[2*ITEM_W-1:ITEM_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q <= '0;
      beat_q <= '0;
    end else if (wr_valid_i && wr_hdr_i) begin
      tags_q <= wr_data_i;
      beat_q <= '0;
    end else if (push_o) begin
      beat_q <= (beat_q == BEAT_W'(BEATS-1)) ? '0 : beat_q + 1'b1;
    end
  end

  assert_beat_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && beat_q == BEAT_W'(BEATS-1)) |=> (beat_q == '0));
  assert_hdr_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_hdr_i) |=> (beat_q == '0));
endmodule

// File: rtl/iq_queue.sv
module iq_queue
  import iq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH+1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  iq_item_t                   item0_i,
  input  iq_item_t                   item1_i,
  input  logic                       rm_en_i,
  input  logic [IDX_W-1:0]           rm_idx_i,
  output logic [ITEM_W-1:0]          rm_data_o,
  output logic [NREG-1:0]            hit_o,
  output logic [NREG-1:0][IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0]           level_o,
  output logic                       ovf_o
);
  iq_item_t         q_q  [DEPTH];
  iq_item_t         q_nx [DEPTH];
  logic [CNT_W-1:0] cnt_q, base;
  logic             accept, ovf_q;

  assign accept    = push_i && (cnt_q <= CNT_W'(DEPTH-2));
  assign base      = cnt_q - CNT_W'(rm_en_i);
  assign rm_data_o = q_q[rm_idx_i].data;
  assign level_o   = cnt_q;
  assign ovf_o     = ovf_q;

  // compacting shift keeps entries in arrival order
  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_nx[i] = q_q[i];
    for (int i = 0; i < DEPTH-1; i++)
      if (rm_en_i && rm_idx_i <= IDX_W'(i)) q_nx[i] = q_q[i+1];
    if (accept) begin
      q_nx[base[IDX_W-1:0]]        = item0_i;
      q_nx[base[IDX_W-1:0] + 1'b1] = item1_i;
    end
  end

  // oldest match per tag: scan downward so the lowest index wins
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      hit_o[r] = 1'b0;
      idx_o[r] = '0;
      for (int i = DEPTH-1; i >= 0; i--) begin
        if (CNT_W'(i) < cnt_q && q_q[i].tag == TAG_W'(r)) begin
          hit_o[r] = 1'b1;
          idx_o[r] = IDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else begin
      cnt_q <= base + (accept ? CNT_W'(2) : CNT_W'(0));
      if (push_i && !accept) ovf_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= q_nx[i];
    end
  end

  assert_level_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_rm_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_en_i |-> (CNT_W'(rm_idx_i) < cnt_q));
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q > CNT_W'(DEPTH-2)) |=> (cnt_q <= $past(cnt_q)));
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/iq_regfile.sv
module iq_regfile
  import iq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NREG-1:0]            hit_i,
  input  logic [NREG-1:0][IDX_W-1:0] idx_i,
  input  logic [ITEM_W-1:0]          rm_data_i,
  output logic                       rm_en_o,
  output logic [IDX_W-1:0]           rm_idx_o,
  input  logic                       rd_req_i,
  input  logic [TAG_W-1:0]           rd_reg_i,
  output logic [ITEM_W-1:0]          rd_data_o,
  output logic                       rd_ok_o,
  output logic                       stall_o
);
  logic [ITEM_W-1:0] val_q [NREG];
  logic [NREG-1:0]   full_q, cons, cand;
  logic [TAG_W-1:0]  sel;

  assign rd_data_o = val_q[rd_reg_i];
  assign rd_ok_o   = full_q[rd_reg_i];
  assign stall_o   = rd_req_i & ~full_q[rd_reg_i];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      cons[r] = rd_req_i && full_q[r] && (rd_reg_i == TAG_W'(r));
      cand[r] = (~full_q[r] | cons[r]) & hit_i[r];
    end
  end

  // lowest-index register wins the single refill slot
  always_comb begin
    sel     = '0;
    rm_en_o = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (cand[r] && !rm_en_o) begin
        sel     = TAG_W'(r);
        rm_en_o = 1'b1;
      end
    end
  end
  assign rm_idx_o = idx_i[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      for (int r = 0; r < NREG; r++) val_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (rm_en_o && sel == TAG_W'(r)) begin
          full_q[r] <= 1'b1;
          val_q[r]  <= rm_data_i;
        end else if (cons[r]) begin
          full_q[r] <= 1'b0;
        end
      end
    end
  end

  assert_single_refill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(full_q & ~$past(full_q)) <= 1));
  assert_consume_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_ok_o && !hit_i[rd_reg_i]) |=> !full_q[$past(rd_reg_i)]);
  assert_stall_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !hit_i[rd_reg_i]) |=> !full_q[$past(rd_reg_i)]);
endmodule

// File: rtl/iq_ofifo.sv
module iq_ofifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_push_full_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
  assert_pop_empty_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/reorder_iq.sv
module reorder_iq
  import iq_pkg::*;
#(
  parameter int IN_DEPTH  = 16,
  parameter int OUT_DEPTH = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_valid_i,
  input  logic                          wr_hdr_i,
  input  logic [31:0]                   wr_data_i,
  output logic [$clog2(IN_DEPTH+1)-1:0] in_level_o,
  output logic                          in_ovf_o,
  input  logic                          rd_req_i,
  input  logic [3:0]                    rd_reg_i,
  output logic [15:0]                   rd_data_o,
  output logic                          rd_ok_o,
  output logic                          stall_o,
  input  logic                          res_push_i,
  input  logic [31:0]                   res_data_i,
  input  logic                          res_pop_i,
  output logic [31:0]                   res_data_o,
  output logic                          res_full_o,
  output logic                          res_empty_o
);
  localparam int IDX_W = $clog2(IN_DEPTH);

  logic                       push;
  iq_item_t                   item0, item1;
  logic                       rm_en;
  logic [IDX_W-1:0]           rm_idx;
  logic [ITEM_W-1:0]          rm_data;
  logic [NREG-1:0]            hit;
  logic [NREG-1:0][IDX_W-1:0] idx;

  iq_hdr u_hdr (
    .clk_i, .rst_ni, .wr_valid_i, .wr_hdr_i, .wr_data_i,
    .push_o(push), .item0_o(item0), .item1_o(item1)
  );

  iq_queue #(.DEPTH(IN_DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i(push), .item0_i(item0), .item1_i(item1),
    .rm_en_i(rm_en), .rm_idx_i(rm_idx), .rm_data_o(rm_data),
    .hit_o(hit), .idx_o(idx), .level_o(in_level_o), .ovf_o(in_ovf_o)
  );

  iq_regfile #(.DEPTH(IN_DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .hit_i(hit), .idx_i(idx), .rm_data_i(rm_data),
    .rm_en_o(rm_en), .rm_idx_o(rm_idx),
    .rd_req_i, .rd_reg_i, .rd_data_o, .rd_ok_o, .stall_o
  );

  iq_ofifo #(.DEPTH(OUT_DEPTH), .W(32)) u_ofifo (
    .clk_i, .rst_ni,
    .push_i(res_push_i), .data_i(res_data_i), .pop_i(res_pop_i),
    .data_o(res_data_o), .full_o(res_full_o), .empty_o(res_empty_o)
  );
endmodule

// File: tb/reorder_iq_tb.sv
module reorder_iq_tb;
  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, wr_hdr = 0;
  logic [31:0] wr_data = '0;
  logic [4:0]  in_level;
  logic        in_ovf;
  logic        rd_req = 0;
  logic [3:0]  rd_reg = '0;
  logic [15:0] rd_data;
  logic        rd_ok, stall;
  logic        res_push = 0, res_pop = 0;
  logic [31:0] res_din = '0, res_dout;
  logic        res_full, res_empty;

  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reorder_iq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_hdr_i(wr_hdr), .wr_data_i(wr_data),
    .in_level_o(in_level), .in_ovf_o(in_ovf),
    .rd_req_i(rd_req), .rd_reg_i(rd_reg), .rd_data_o(rd_data),
    .rd_ok_o(rd_ok), .stall_o(stall),
    .res_push_i(res_push), .res_data_i(res_din), .res_pop_i(res_pop),
    .res_data_o(res_dout), .res_full_o(res_full), .res_empty_o(res_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic hdr, input logic [31:0] d);
    wr_valid = 1; wr_hdr = hdr; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_hdr = 0;
  endtask

  task automatic consume(input logic [3:0] r);
    rd_req = 1; rd_reg = r;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic peek(input logic [3:0] r);
    rd_reg = r; #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1;
    chk("R1 level", 32'(in_level), 0);
    chk("R1 ovf", 32'(in_ovf), 0);
    chk("R1 rd_ok", 32'(rd_ok), 0);
    chk("R1 res_empty", 32'(res_empty), 1);
    chk("R1 res_full", 32'(res_full), 0);
    @(negedge clk);
    rst_n = 1;
    idle(1);

    // R2 R3 R4: tags 0..7 on beats 0..7
    wr(1, 32'h7654_3210);
    for (int k = 0; k < 8; k++)
      wr(0, {16'(16'h1001 + 2*k), 16'(16'h1000 + 2*k)});
    idle(20);
    chk("R3 level after 8 refills", 32'(in_level), 8);
    for (int r = 0; r < 8; r++) begin
      peek(4'(r));
      chk("R2 R4 tag routing ok", 32'(rd_ok), 1);
      chk("R2 R4 oldest item", 32'(rd_data), 32'(16'h1000 + 2*r));
    end
    for (int r = 8; r < 16; r++) begin
      peek(4'(r));
      chk("R4 unmatched register empty", 32'(rd_ok), 0);
    end
    @(negedge clk);
    for (int r = 0; r < 8; r++) consume(4'(r));
    idle(2);
    for (int r = 0; r < 8; r++) begin
      peek(4'(r));
      chk("R6 refill in order", 32'(rd_data), 32'(16'h1001 + 2*r));
    end
    chk("R3 queue drained", 32'(in_level), 0);
    @(negedge clk);

    // R2 wrap: ninth data beat reuses nibble 0 (tag 0)
    consume(0);
    wr(0, 32'h2001_2000);
    idle(3);
    peek(0);
    chk("R2 wrap tag", 32'(rd_ok), 1);
    chk("R2 wrap data", 32'(rd_data), 32'h2000);
    peek(1);
    chk("R2 wrap not tag1", 32'(rd_data), 32'h1003);
    chk("R2 wrap level", 32'(in_level), 1);
    @(negedge clk);

    // R5 exact refill timing on register 9
    rd_reg = 9;
    wr(1, 32'h0000_0009);
    wr(0, 32'h3001_3000);
    #1;
    chk("R5 level at t", 32'(in_level), 3);
    chk("R5 not yet filled", 32'(rd_ok), 0);
    @(negedge clk); #1;
    chk("R5 filled at t+1", 32'(rd_ok), 1);
    chk("R5 data", 32'(rd_data), 32'h3000);
    chk("R5 level t+1", 32'(in_level), 2);
    @(negedge clk);
    consume(9); #1;
    chk("R6 same-edge refill", 32'(rd_data), 32'h3001);
    chk("R6 same-edge ok", 32'(rd_ok), 1);
    @(negedge clk);
    consume(9);
    rd_req = 1; rd_reg = 9; #1;
    chk("R7 stall", 32'(stall), 1);
    chk("R7 no data", 32'(rd_ok), 0);
    @(negedge clk); #1;
    chk("R7 still stalled", 32'(stall), 1);
    chk("R7 level untouched", 32'(in_level), 1);
    rd_req = 0;
    @(negedge clk);

    // R8 overflow with tag 0 (reg0 full, one tag-0 item queued)
    wr(1, 32'h0);
    for (int k = 0; k < 7; k++)
      wr(0, {16'(16'h4001 + 2*k), 16'(16'h4000 + 2*k)});
    #1;
    chk("R8 level 15", 32'(in_level), 15);
    chk("R8 no ovf yet", 32'(in_ovf), 0);
    @(negedge clk);
    wr(0, 32'hBEEF_BEEF);
    #1;
    chk("R8 dropped level", 32'(in_level), 15);
    chk("R8 ovf set", 32'(in_ovf), 1);
    @(negedge clk);

    // R6 streaming: one item per cycle from register 0
    rd_req = 1; rd_reg = 0;
    for (int i = 0; i < 16; i++) begin
      #1;
      chk("R6 stream ok", 32'(rd_ok), 1);
      chk("R6 stream data", 32'(rd_data),
          (i < 2) ? 32'(16'h2000 + i) : 32'(16'h4000 + i - 2));
      @(negedge clk);
    end
    #1;
    chk("R7 stall after drain", 32'(stall), 1);
    chk("R8 ovf sticky", 32'(in_ovf), 1);
    chk("R8 drained level", 32'(in_level), 0);
    rd_req = 0;
    @(negedge clk);

    // R9 output FIFO
    for (int i = 0; i < 8; i++) begin
      chk("R9 not full", 32'(res_full), 0);
      res_push = 1; res_din = 32'hA500_0000 + i;
      @(negedge clk);
    end
    res_push = 0;
    chk("R9 full", 32'(res_full), 1);
    chk("R9 not empty", 32'(res_empty), 0);
    res_push = 1; res_din = 32'hDEAD_BEEF;
    @(negedge clk);
    res_push = 0;
    for (int i = 0; i < 8; i++) begin
      chk("R9 fifo order", res_dout, 32'hA500_0000 + i);
      res_pop = 1;
      @(negedge clk);
      res_pop = 0;
    end
    chk("R9 empty", 32'(res_empty), 1);
    res_pop = 1;
    @(negedge clk);
    res_pop = 0;
    res_push = 1; res_din = 32'h77;
    @(negedge clk);
    res_push = 0;
    chk("R9 pop-empty ignored", res_dout, 32'h77);
    chk("R9 one entry", 32'(res_empty), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule